// File: doc/BRIEF.md
# Preamble Timing Detector

This block watches a stream of complex baseband samples and marks where a burst begins and where its repeated short training section ends. A lag-16 autocorrelator compares each sample with the one sixteen samples earlier and keeps a moving sum over a 16-sample window. The moving sum is also exported, with a fresh-value strobe, to a downstream frequency-offset estimator. A 16-tap matched filter correlates the stream with a coarse copy of the short training symbol. Its taps take only the values 0, +1, -1, +j and -j, so it needs no multipliers.

Both correlator outputs go through an approximate magnitude unit. A small control machine compares them with a threshold that is captured while reset is held. The machine first looks for a sustained autocorrelation plateau. It then counts matched-filter peaks and flags the end of the short section either on the tenth peak or when the peaks stop arriving.

Top module: `preamble_timing_det`

## Requirements
- R1: For the n-th accepted sample x[n] (valid_i high at a rising clock edge), the autocorrelation output becomes A[n] = sum over k=0..15 of x[n-16-k]*conj(x[n-k]). Samples before the first one after reset count as zero. The value is visible from the edge of acceptance until the next accepted sample, and acorr_vld_o is high for the one cycle after each acceptance.
- R2: The moving sum never wraps, even when every input component is at full scale, including the most negative code.
- R3: The matched filter output is C[n] = sum over m=1..16 of x[n-16+m]*conj(t(m)). The tap sequence t(1..16), from the oldest sample to the newest, is 0, -1, -j, 1, 1, 1, -j, -1, 0, -j, -1, j, j, j, -1, -j.
- R4: The magnitude of a complex value is max(|re|,|im|) + floor(min(|re|,|im|)/2). The autocorrelation test is magnitude > T. The matched-filter test is magnitude > 10*T.
- R5: While searching, frame_det_o pulses for one cycle on the 16th consecutive accepted sample that passes the autocorrelation test. The pulse appears in the second cycle after that sample is accepted, and the block then starts counting peaks.
- R6: While counting peaks, a peak is an accepted sample that passes the matched-filter test when the previous accepted sample did not. Each peak gives a one-cycle sym_bound_o pulse with the same two-cycle latency.
- R7: The tenth peak after a frame detection pulses sp_end_o together with sym_bound_o, and the block returns to searching.
- R8: After at least one peak, the 21st consecutive accepted sample without a peak pulses sp_end_o, and the block returns to searching.
- R9: If no peak follows a frame detection within 21 accepted samples, the block returns to searching without pulsing sp_end_o.
- R10: The threshold T is taken from thr_i while rst_ni is low. Changes on thr_i after reset have no effect.
- R11: While in reset, all pulse outputs, acorr_vld_o and both autocorrelation outputs are zero.
- R12: A cycle with valid_i low advances nothing. The autocorrelation outputs hold and no pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; threshold is captured while low |
| valid_i | input | 1 | Sample strobe |
| smp_re_i | input | SMP_W | Sample real part, signed |
| smp_im_i | input | SMP_W | Sample imaginary part, signed |
| thr_i | input | ACC_W | Autocorrelation threshold T, unsigned |
| frame_det_o | output | 1 | Burst-start pulse |
| sym_bound_o | output | 1 | Short-symbol boundary pulse |
| sp_end_o | output | 1 | End-of-short-section pulse |
| acorr_vld_o | output | 1 | Autocorrelation output refreshed |
| acorr_re_o | output | ACC_W | Autocorrelation real part, signed |
| acorr_im_o | output | ACC_W | Autocorrelation imaginary part, signed |

## Verification
Low-level noise run with a zeroed threshold input shows whether the captured threshold or the live pin is used. Ten and six repetitions of the scaled tap pattern tell the peak-count ending apart from the gap ending, and a tap sequence reversed or misordered changes where the peaks fall. A constant-level burst raises the autocorrelation without matched-filter peaks, which separates the silent return from a real end. Full-scale constant samples expose any wrap in the moving sum. Random samples with idle gaps carrying junk data show that held outputs and latencies do not depend on the valid pattern.

// File: rtl/ptd_pkg.sv
package ptd_pkg;

  typedef enum logic [2:0] {TAP_ZERO, TAP_POS, TAP_NEG, TAP_PJ, TAP_NJ} tap_e;

  typedef enum logic {ST_HUNT, ST_SYNC} det_st_e;

  // tap index 0 multiplies the oldest sample in the window
  function automatic tap_e tap_coef(input int t);
    case (t)
      0, 8:              return TAP_ZERO;
      1, 7, 10, 14:      return TAP_NEG;
      3, 4, 5:           return TAP_POS;
      11, 12, 13:        return TAP_PJ;
      default:           return TAP_NJ;
    endcase
  endfunction

endpackage

// File: rtl/ptd_autocorr.sv
module ptd_autocorr #(
  parameter int SMP_W = 8,
  parameter int LAG   = 16,
  parameter int ACC_W = 21
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [SMP_W-1:0] new_re_i,
  input  logic signed [SMP_W-1:0] new_im_i,
  input  logic signed [SMP_W-1:0] old_re_i,
  input  logic signed [SMP_W-1:0] old_im_i,
  output logic signed [ACC_W-1:0] acc_re_o,
  output logic signed [ACC_W-1:0] acc_im_o
);
  localparam int P_W = 2 * SMP_W + 1;

  logic signed [P_W-1:0] prod_re, prod_im;
  logic signed [P_W-1:0] pd_re_q [LAG];
  logic signed [P_W-1:0] pd_im_q [LAG];

  // old * conj(new)
  assign prod_re = P_W'(old_re_i) * P_W'(new_re_i) + P_W'(old_im_i) * P_W'(new_im_i);
  assign prod_im = P_W'(old_im_i) * P_W'(new_re_i) - P_W'(old_re_i) * P_W'(new_im_i);

  for (genvar k = 0; k < LAG; k++) begin : g_pd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pd_re_q[k] <= '0;
        pd_im_q[k] <= '0;
      end else if (vld_i) begin
        if (k == 0) begin
          pd_re_q[k] <= prod_re;
          pd_im_q[k] <= prod_im;
        end else begin
          pd_re_q[k] <= pd_re_q[(k == 0) ? 0 : k-1];
          pd_im_q[k] <= pd_im_q[(k == 0) ? 0 : k-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_re_o <= '0;
      acc_im_o <= '0;
    end else if (vld_i) begin
      acc_re_o <= acc_re_o + ACC_W'(prod_re) - ACC_W'(pd_re_q[LAG-1]);
      acc_im_o <= acc_im_o + ACC_W'(prod_im) - ACC_W'(pd_im_q[LAG-1]);
    end
  end

endmodule

// File: rtl/ptd_xcorr.sv
module ptd_xcorr
  import ptd_pkg::*;
#(
  parameter int SMP_W = 8,
  parameter int LAG   = 16,
  parameter int XC_W  = 13
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [SMP_W-1:0] tap_re_i [LAG],
  input  logic signed [SMP_W-1:0] tap_im_i [LAG],
  output logic signed [XC_W-1:0]  xc_re_o,
  output logic signed [XC_W-1:0]  xc_im_o
);
  logic signed [XC_W-1:0] cr [LAG];
  logic signed [XC_W-1:0] ci [LAG];
  logic signed [XC_W-1:0] sum_re, sum_im;

  // conj(tap) * sample, sign swaps only
  for (genvar t = 0; t < LAG; t++) begin : g_tap
    localparam tap_e CF = tap_coef(t);
    logic signed [XC_W-1:0] ar, ai;
    assign ar = XC_W'(tap_re_i[t]);
    assign ai = XC_W'(tap_im_i[t]);
    if (CF == TAP_POS) begin : g_pos
      assign cr[t] = ar;
      assign ci[t] = ai;
    end else if (CF == TAP_NEG) begin : g_neg
      assign cr[t] = -ar;
      assign ci[t] = -ai;
    end else if (CF == TAP_PJ) begin : g_pj
      assign cr[t] = ai;
      assign ci[t] = -ar;
    end else if (CF == TAP_NJ) begin : g_nj
      assign cr[t] = -ai;
      assign ci[t] = ar;
    end else begin : g_zero
      assign cr[t] = '0;
      assign ci[t] = '0;
      logic unused_z;
      assign unused_z = ^{ar, ai};
    end
  end

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int t = 0; t < LAG; t++) begin
      sum_re = sum_re + cr[t];
      sum_im = sum_im + ci[t];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xc_re_o <= '0;
      xc_im_o <= '0;
    end else if (vld_i) begin
      xc_re_o <= sum_re;
      xc_im_o <= sum_im;
    end
  end

endmodule

// File: rtl/ptd_mag.sv
module ptd_mag #(
  parameter int IN_W = 21
) (
  input  logic signed [IN_W-1:0] re_i,
  input  logic signed [IN_W-1:0] im_i,
  output logic        [IN_W:0]   mag_o
);
  logic signed [IN_W:0] re_x, im_x;
  logic        [IN_W:0] ar, ai, mx, mn;

  assign re_x = (IN_W+1)'(re_i);
  assign im_x = (IN_W+1)'(im_i);
  assign ar   = (re_x < 0) ? (IN_W+1)'(-re_x) : (IN_W+1)'(re_x);
  assign ai   = (im_x < 0) ? (IN_W+1)'(-im_x) : (IN_W+1)'(im_x);
  assign mx   = (ar > ai) ? ar : ai;
  assign mn   = (ar > ai) ? ai : ar;
  assign mag_o = mx + (mn >> 1);

endmodule

// File: rtl/ptd_peak_fsm.sv
module ptd_peak_fsm
  import ptd_pkg::*;
#(
  parameter int MA_W  = 22,
  parameter int MC_W  = 14,
  parameter int THR_W = 21,
  parameter int HOLD  = 16,
  parameter int PEAKS = 10,
  parameter int GAP   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [MA_W-1:0]  mag_a_i,
  input  logic [MC_W-1:0]  mag_c_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             frame_o,
  output logic             sym_o,
  output logic             end_o
);
  localparam int T10_W = THR_W + 4;
  localparam int CA_W  = (MA_W > THR_W) ? MA_W : THR_W;
  localparam int CC_W  = (MC_W > T10_W) ? MC_W : T10_W;
  localparam int RUN_W = $clog2(HOLD);
  localparam int PK_W  = $clog2(PEAKS);
  localparam int GAP_W = $clog2(GAP + 1);

  det_st_e          st_q;
  logic [RUN_W-1:0] run_q;
  logic [PK_W-1:0]  npk_q;
  logic [GAP_W-1:0] gap_q;
  logic             cprev_q;
  logic [T10_W-1:0] thr10;
  logic             a_hi, c_hi, peak;

  assign thr10 = (T10_W'(thr_i) << 3) + (T10_W'(thr_i) << 1);
  assign a_hi  = CA_W'(mag_a_i) > CA_W'(thr_i);
  assign c_hi  = CC_W'(mag_c_i) > CC_W'(thr10);
  assign peak  = c_hi && !cprev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      run_q   <= '0;
      npk_q   <= '0;
      gap_q   <= '0;
      cprev_q <= 1'b0;
      frame_o <= 1'b0;
      sym_o   <= 1'b0;
      end_o   <= 1'b0;
    end else begin
      frame_o <= 1'b0;
      sym_o   <= 1'b0;
      end_o   <= 1'b0;
      if (vld_i) begin
        cprev_q <= c_hi;
        unique case (st_q)
          ST_HUNT: begin
            if (!a_hi) begin
              run_q <= '0;
            end else if (run_q == RUN_W'(HOLD - 1)) begin
              frame_o <= 1'b1;
              st_q    <= ST_SYNC;
              run_q   <= '0;
              npk_q   <= '0;
              gap_q   <= '0;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end
          ST_SYNC: begin
            if (peak) begin
              sym_o <= 1'b1;
              gap_q <= '0;
              if (npk_q == PK_W'(PEAKS - 1)) begin
                end_o <= 1'b1;
                st_q  <= ST_HUNT;
              end else begin
                npk_q <= npk_q + 1'b1;
              end
            end else if (gap_q == GAP_W'(GAP)) begin
              end_o <= (npk_q != '0);  // silent if no peak seen
              st_q  <= ST_HUNT;
            end else begin
              gap_q <= gap_q + 1'b1;
            end
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/preamble_timing_det.sv
module preamble_timing_det
  import ptd_pkg::*;
#(
  parameter  int SMP_W     = 8,
  parameter  int LAG       = 16,
  parameter  int HOLD_LEN  = 16,
  parameter  int PEAK_CNT  = 10,
  parameter  int GAP_LEN   = 20,
  localparam int ACC_W     = 2 * SMP_W + 1 + $clog2(LAG),
  localparam int XC_W      = SMP_W + 1 + $clog2(LAG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [SMP_W-1:0] smp_re_i,
  input  logic signed [SMP_W-1:0] smp_im_i,
  input  logic        [ACC_W-1:0] thr_i,
  output logic                    frame_det_o,
  output logic                    sym_bound_o,
  output logic                    sp_end_o,
  output logic                    acorr_vld_o,
  output logic signed [ACC_W-1:0] acorr_re_o,
  output logic signed [ACC_W-1:0] acorr_im_o
);
  logic signed [SMP_W-1:0] win_re_q [LAG];
  logic signed [SMP_W-1:0] win_im_q [LAG];
  logic signed [SMP_W-1:0] tap_re   [LAG];
  logic signed [SMP_W-1:0] tap_im   [LAG];
  logic signed [XC_W-1:0]  xc_re, xc_im;
  logic        [ACC_W:0]   mag_a;
  logic        [XC_W:0]    mag_c;
  logic        [ACC_W-1:0] thr_q;

  // threshold loaded only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= thr_i;
    else         thr_q <= thr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acorr_vld_o <= 1'b0;
    else         acorr_vld_o <= valid_i;
  end

  // sample window, index 0 newest
  for (genvar k = 0; k < LAG; k++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_re_q[k] <= '0;
        win_im_q[k] <= '0;
      end else if (valid_i) begin
        if (k == 0) begin
          win_re_q[k] <= smp_re_i;
          win_im_q[k] <= smp_im_i;
        end else begin
          win_re_q[k] <= win_re_q[(k == 0) ? 0 : k-1];
          win_im_q[k] <= win_im_q[(k == 0) ? 0 : k-1];
        end
      end
    end
  end

  // tap t sees x[n-LAG+1+t]; last tap is the incoming sample
  for (genvar t = 0; t < LAG; t++) begin : g_tapmap
    if (t == LAG - 1) begin : g_new
      assign tap_re[t] = smp_re_i;
      assign tap_im[t] = smp_im_i;
    end else begin : g_old
      assign tap_re[t] = win_re_q[LAG-2-t];
      assign tap_im[t] = win_im_q[LAG-2-t];
    end
  end

  ptd_autocorr #(.SMP_W(SMP_W), .LAG(LAG), .ACC_W(ACC_W)) u_acorr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (valid_i),
    .new_re_i (smp_re_i),
    .new_im_i (smp_im_i),
    .old_re_i (win_re_q[LAG-1]),
    .old_im_i (win_im_q[LAG-1]),
    .acc_re_o (acorr_re_o),
    .acc_im_o (acorr_im_o)
  );

  ptd_xcorr #(.SMP_W(SMP_W), .LAG(LAG), .XC_W(XC_W)) u_xcorr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (valid_i),
    .tap_re_i (tap_re),
    .tap_im_i (tap_im),
    .xc_re_o  (xc_re),
    .xc_im_o  (xc_im)
  );

  ptd_mag #(.IN_W(ACC_W)) u_mag_a (
    .re_i  (acorr_re_o),
    .im_i  (acorr_im_o),
    .mag_o (mag_a)
  );

  ptd_mag #(.IN_W(XC_W)) u_mag_c (
    .re_i  (xc_re),
    .im_i  (xc_im),
    .mag_o (mag_c)
  );

  ptd_peak_fsm #(
    .MA_W (ACC_W + 1),
    .MC_W (XC_W + 1),
    .THR_W(ACC_W),
    .HOLD (HOLD_LEN),
    .PEAKS(PEAK_CNT),
    .GAP  (GAP_LEN)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (acorr_vld_o),
    .mag_a_i (mag_a),
    .mag_c_i (mag_c),
    .thr_i   (thr_q),
    .frame_o (frame_det_o),
    .sym_o   (sym_bound_o),
    .end_o   (sp_end_o)
  );

endmodule

// File: rtl/ptd_checker.sv
module ptd_checker #(
  parameter int SMP_W = 8,
  parameter int LAG   = 16,
  parameter int ACC_W = 21
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    frame_det_o,
  input logic                    sym_bound_o,
  input logic                    sp_end_o,
  input logic signed [ACC_W-1:0] acorr_re_o,
  input logic signed [ACC_W-1:0] acorr_im_o
);
  localparam longint LIM = longint'(LAG) * 2 * (longint'(1) << (2 * SMP_W - 2));

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'(acorr_re_o) <= LIM) && (longint'(acorr_re_o) >= -LIM) &&
    (longint'(acorr_im_o) <= LIM) && (longint'(acorr_im_o) >= -LIM));

  a_r12_acorr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(acorr_re_o) && $stable(acorr_im_o)));

  a_r12_pulse_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_det_o || sym_bound_o || sp_end_o) |-> $past(valid_i, 2));

  a_r5_frame_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_det_o |=> !frame_det_o);

  a_r6_frame_not_sym: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frame_det_o, sym_bound_o}));

  a_r7_hunt_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_end_o |=> !sym_bound_o);

endmodule

bind preamble_timing_det ptd_checker #(
  .SMP_W(SMP_W),
  .LAG  (LAG),
  .ACC_W(ACC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .frame_det_o(frame_det_o),
  .sym_bound_o(sym_bound_o),
  .sp_end_o   (sp_end_o),
  .acorr_re_o (acorr_re_o),
  .acorr_im_o (acorr_im_o)
);

// File: tb/preamble_timing_det_tb.sv
module preamble_timing_det_tb;
  localparam int SMP_W = 8;
  localparam int ACC_W = 21;
  localparam int THR0  = 50;

  logic clk = 1'b0;
  logic rst_ni;
  logic valid_i;
  logic signed [SMP_W-1:0] smp_re_i, smp_im_i;
  logic [ACC_W-1:0] thr_i;
  logic frame_det_o, sym_bound_o, sp_end_o, acorr_vld_o;
  logic signed [ACC_W-1:0] acorr_re_o, acorr_im_o;

  always #4 clk = ~clk;

  preamble_timing_det u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .smp_re_i(smp_re_i), .smp_im_i(smp_im_i), .thr_i(thr_i),
    .frame_det_o(frame_det_o), .sym_bound_o(sym_bound_o), .sp_end_o(sp_end_o),
    .acorr_vld_o(acorr_vld_o), .acorr_re_o(acorr_re_o), .acorr_im_o(acorr_im_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int xr [0:4095];
  int xi [0:4095];
  int ns = 0;
  int ref_re [16] = '{0,-1, 0,1,1,1, 0,-1,0, 0,-1,0,0,0,-1, 0};
  int ref_im [16] = '{0, 0,-1,0,0,0,-1, 0,0,-1, 0,1,1,1, 0,-1};

  // model state
  bit m_sync = 0, m_cprev = 0;
  int m_run = 0, m_npk = 0, m_gap = 0;
  longint exp_re = 0, exp_im = 0;
  bit last_v = 0;
  bit d1_f = 0, d1_s = 0, d1_e = 0, d2_f = 0, d2_s = 0, d2_e = 0;
  string cur_tag = "R1";
  string acc_tag = "R1";

  function automatic longint gx(int idx, bit im);
    if (idx < 0) return 0;
    return im ? longint'(xi[idx]) : longint'(xr[idx]);
  endfunction

  function automatic longint amag(longint a, longint b);
    longint aa = (a < 0) ? -a : a;
    longint bb = (b < 0) ? -b : b;
    longint mx = (aa > bb) ? aa : bb;
    longint mn = (aa > bb) ? bb : aa;
    return mx + mn / 2;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_one(int re, int im, output bit f, output bit s, output bit e);
    longint are = 0, aim = 0, cre = 0, cim = 0, ma, mc;
    bit ahi, chi, pk;
    int n;
    f = 0; s = 0; e = 0;
    xr[ns] = re; xi[ns] = im; n = ns; ns++;
    for (int k = 0; k < 16; k++) begin
      longint o_r = gx(n-16-k, 0), o_i = gx(n-16-k, 1);
      longint w_r = gx(n-k, 0),    w_i = gx(n-k, 1);
      are += o_r * w_r + o_i * w_i;
      aim += o_i * w_r - o_r * w_i;
    end
    for (int m = 1; m <= 16; m++) begin
      longint a = gx(n-16+m, 0), b = gx(n-16+m, 1);
      cre += ref_re[m-1] * a + ref_im[m-1] * b;
      cim += ref_re[m-1] * b - ref_im[m-1] * a;
    end
    exp_re = are; exp_im = aim;
    ma = amag(are, aim);
    mc = amag(cre, cim);
    ahi = ma > THR0;
    chi = mc > 10 * THR0;
    pk  = chi && !m_cprev;
    m_cprev = chi;
    if (!m_sync) begin
      if (!ahi) m_run = 0;
      else if (m_run == 15) begin
        f = 1; m_sync = 1; m_run = 0; m_npk = 0; m_gap = 0;
      end else m_run++;
    end else begin
      if (pk) begin
        s = 1; m_gap = 0;
        if (m_npk == 9) begin e = 1; m_sync = 0; end
        else m_npk++;
      end else if (m_gap == 20) begin
        e = (m_npk != 0); m_sync = 0;
      end else m_gap++;
    end
  endtask

  task automatic step(bit v, int re, int im);
    bit f = 0, s = 0, e = 0;
    @(negedge clk);
    chk(acorr_vld_o == last_v, last_v ? acc_tag : "R12", "acorr_vld_o", acorr_vld_o, last_v);
    chk(longint'(acorr_re_o) == exp_re, last_v ? acc_tag : "R12", "acorr_re_o", acorr_re_o, exp_re);
    chk(longint'(acorr_im_o) == exp_im, last_v ? acc_tag : "R12", "acorr_im_o", acorr_im_o, exp_im);
    chk(frame_det_o == d2_f, (cur_tag == "R10") ? "R10" : "R5", "frame_det_o", frame_det_o, d2_f);
    chk(sym_bound_o == d2_s, "R3,R4,R6", "sym_bound_o", sym_bound_o, d2_s);
    chk(sp_end_o == d2_e, cur_tag, "sp_end_o", sp_end_o, d2_e);
    valid_i  = v;
    smp_re_i = SMP_W'(re);
    smp_im_i = SMP_W'(im);
    if (v) model_one(re, im, f, s, e);
    last_v = v;
    d2_f = d1_f; d2_s = d1_s; d2_e = d1_e;
    d1_f = f;    d1_s = s;    d1_e = e;
  endtask

  function automatic int noise1();
    return int'($urandom_range(2)) - 1;
  endfunction

  // optional idle cycle with junk data, then the sample
  task automatic put(int re, int im);
    if ($urandom_range(7) == 0)
      step(0, int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128);
    step(1, re, im);
  endtask

  task automatic preamble(int reps, int amp);
    for (int r = 0; r < reps; r++)
      for (int m = 0; m < 16; m++)
        put(amp * ref_re[m] + noise1(), amp * ref_im[m] + noise1());
  endtask

  task automatic noise_run(int len);
    for (int i = 0; i < len; i++) put(noise1(), noise1());
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 1'b0; valid_i = 1'b0; smp_re_i = '0; smp_im_i = '0;
    thr_i = ACC_W'(THR0);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(frame_det_o == 0 && sym_bound_o == 0 && sp_end_o == 0, "R11", "pulses", {frame_det_o, sym_bound_o, sp_end_o}, 0);
    chk(acorr_vld_o == 0, "R11", "acorr_vld_o", acorr_vld_o, 0);
    chk(acorr_re_o == 0, "R11", "acorr_re_o", acorr_re_o, 0);
    chk(acorr_im_o == 0, "R11", "acorr_im_o", acorr_im_o, 0);
    rst_ni = 1'b1;

    // R10: live threshold of zero must be ignored on low-level noise
    cur_tag = "R10";
    thr_i = '0;
    noise_run(40);

    // R7: full ten-symbol section
    cur_tag = "R7";
    thr_i = '1;
    preamble(10, 40);
    noise_run(40);

    // R8: six symbols then silence
    cur_tag = "R8";
    preamble(6, 40);
    noise_run(60);

    // R9: plateau without matched-filter peaks
    cur_tag = "R9";
    for (int i = 0; i < 50; i++) put(40, 0);
    noise_run(30);

    // R2: full-scale samples
    cur_tag = "R2"; acc_tag = "R2";
    for (int i = 0; i < 40; i++) put(-128, -128);
    for (int i = 0; i < 20; i++) put(-128, 127);
    acc_tag = "R1";
    noise_run(30);

    // R12: idle cycles with junk data, then random traffic
    cur_tag = "R12";
    for (int i = 0; i < 20; i++)
      step(0, int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128);
    cur_tag = "R1";
    for (int i = 0; i < 150; i++) begin
      bit v = ($urandom_range(4) != 0);
      step(v, int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128);
    end
    cur_tag = "R8";
    preamble(3, 60);
    noise_run(30);
    for (int i = 0; i < 4; i++) step(0, 0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule